// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge and serves it through a byte-wide request port. Each request carries a function number, a byte offset, a write flag and write data. Writes pass through a per-offset filter before they reach storage. Depending on the offset and on the chip generation, the filter keeps only some bits, forces others, replaces the value, or drops the write. Identification bytes are read-only. Every byte starts from a reset default that depends on the generation.

The block exports the control bytes that neighbouring logic decodes. These are the seven memory attribute bytes, the system-management RAM control byte, and an external cache enable taken from the cache control byte. The parameter `GEN` selects the variant: 0 = older generation, 1 = newer generation, 2 = newer generation board variant, 3 = newest generation. `DEV_ID` and `REV_ID` give the identification bytes.

The request side is a valid/ready stream. `req_ready` is held high, so a request is taken in every cycle in which `req_valid` is high, and the requester never stalls. A taken read produces `rsp_valid` with `rsp_rdata` exactly one cycle later. The response channel cannot be back-pressured: the consumer must take it in that cycle.

Top module: `bridge_cfg_regs`

## Requirements
- R1: A request whose function number is nonzero changes no stored byte when it writes, and a read of it returns FFh.
- R2: Writes with function 0 to offsets 00h-03h, 08h-0Ch, 0Eh and 10h-4Eh are dropped; those bytes keep their reset values (00h = 86h, 01h = 80h, 02h/03h = DEV_ID low/high, 08h = REV_ID, 0Bh = 06h, others 00h).
- R3: A write to offset 04h stores the data masked to bits 1 and 6 (GEN 0), bits 1 and 2 (GEN 2) or bit 1 (GEN 1, 3), then ORed with 04h.
- R4: A write to offset 05h stores data AND 01h for GEN 0 and 00h for all other generations.
- R5: A write to offset 06h always stores 00h.
- R6: A write to offset 07h stores (data AND 80h) OR 02h for GEN 3, 22h for GEN 2, and 02h for GEN 0 and 1.
- R7: After reset: 00h = 86h, 01h = 80h, 04h = 06h, 07h = 02h, 0Bh = 06h, 60h-64h = 02h, the ID bytes as in R2, and every other offset not named in R8 = 00h. No response is pending.
- R8: The reset value of offset 57h is 31h for GEN 0 and 01h otherwise. Offset 72h resets to 00h for GEN 0 and 02h otherwise.
- R9: `cache_en` equals bit 0 of offset 52h and follows a write in the next cycle.
- R10: `req_ready` is always high. A write commits on the clock edge where it is taken. A taken read yields `rsp_valid` and the stored byte one cycle later. No `rsp_valid` appears without a read, and nothing is written while `req_valid` is low.
- R11: Offsets 59h-5Fh (attribute bytes, offset 59h+k at `attr_ctl` bits 8k+7:8k) and 72h (`smram_ctl`) store all eight bits and drive their outputs from the next cycle.
- R12: Offsets 0Dh, 0Fh, 4Fh and 50h-FFh other than those above store written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Byte offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 8 | Read response data |
| cache_en | output | 1 | External cache enable |
| attr_ctl | output | 56 | Seven memory attribute bytes |
| smram_ctl | output | 8 | System-management RAM control byte |

## Verification
The hardest situations to reach from the ports are the generation-specific masks: a single instance shows the behaviour of only one `GEN`. The bench therefore drives four instances, one per generation, with the same stimulus, and compares each against its own generation in a behavioural model. Every offset is swept with FFh, with 00h and with mixed patterns, and each sweep is read back in full. Writes on nonzero function numbers, and writes presented with `req_valid` low, aim at the exported control bytes, so any leak shows up at once on `smram_ctl`, `attr_ctl` or `cache_en`.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

  typedef enum logic [1:0] {
    GEN_OLDER       = 2'd0,
    GEN_NEWER       = 2'd1,
    GEN_NEWER_BOARD = 2'd2,
    GEN_NEWEST      = 2'd3
  } bcfg_gen_e;

  localparam int unsigned CFG_AW    = 8;
  localparam int unsigned CFG_BYTES = 1 << CFG_AW;
  localparam int unsigned FUNC_W    = 3;

  localparam int unsigned OFF_CMD_LO = 'h04;
  localparam int unsigned OFF_CMD_HI = 'h05;
  localparam int unsigned OFF_STS_LO = 'h06;
  localparam int unsigned OFF_STS_HI = 'h07;
  localparam int unsigned OFF_CACHE  = 'h52;
  localparam int unsigned OFF_DRAM   = 'h57;
  localparam int unsigned OFF_ATTR0  = 'h59;
  localparam int unsigned ATTR_N     = 7;
  localparam int unsigned OFF_SMRAM  = 'h72;

  function automatic logic gen_is_newer(bcfg_gen_e g);
    return g != GEN_OLDER;
  endfunction

  // Reset content of one configuration byte for a given generation.
  function automatic logic [7:0] reset_byte(bcfg_gen_e g, int unsigned off,
                                            logic [15:0] dev_id, logic [7:0] rev_id);
    logic [7:0] v;
    v = 8'h00;
    case (off)
      'h00: v = 8'h86;
      'h01: v = 8'h80;
      'h02: v = dev_id[7:0];
      'h03: v = dev_id[15:8];
      'h04: v = 8'h06;
      'h07: v = 8'h02;
      'h08: v = rev_id;
      'h0B: v = 8'h06;
      'h57: v = gen_is_newer(g) ? 8'h01 : 8'h31;
      'h60, 'h61, 'h62, 'h63, 'h64: v = 8'h02;
      'h72: v = gen_is_newer(g) ? 8'h02 : 8'h00;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/bcfg_wr_filter.sv
module bcfg_wr_filter
  import bcfg_pkg::*;
#(
  parameter bcfg_gen_e GEN = GEN_NEWER
) (
  input  logic                wr_i,
  input  logic [FUNC_W-1:0]   func_i,
  input  logic [CFG_AW-1:0]   off_i,
  input  logic [7:0]          wdata_i,
  output logic                commit_o,
  output logic [7:0]          data_o
);

  localparam logic [7:0] CMD_LO_KEEP = (GEN == GEN_OLDER)       ? 8'h42 :
                                       (GEN == GEN_NEWER_BOARD) ? 8'h06 : 8'h02;
  localparam logic [7:0] CMD_HI_KEEP = (GEN == GEN_OLDER) ? 8'h01 : 8'h00;
  localparam logic [7:0] STS_HI_FIX  = (GEN == GEN_NEWER_BOARD) ? 8'h22 : 8'h02;

  logic dropped;

  always_comb begin
    dropped = (off_i <= 8'h03) ||
              ((off_i >= 8'h08) && (off_i <= 8'h0C)) ||
              (off_i == 8'h0E) ||
              ((off_i >= 8'h10) && (off_i <= 8'h4E));
  end

  always_comb begin
    commit_o = wr_i && (func_i == '0) && !dropped;
    data_o   = wdata_i;
    case (off_i)
      8'(OFF_CMD_LO): data_o = (wdata_i & CMD_LO_KEEP) | 8'h04;
      8'(OFF_CMD_HI): data_o = wdata_i & CMD_HI_KEEP;
      8'(OFF_STS_LO): data_o = 8'h00;
      8'(OFF_STS_HI): data_o = (GEN == GEN_NEWEST) ? ((wdata_i & 8'h80) | 8'h02) : STS_HI_FIX;
      default:        data_o = wdata_i;
    endcase
  end

endmodule

// File: rtl/bcfg_store.sv
module bcfg_store
  import bcfg_pkg::*;
#(
  parameter bcfg_gen_e   GEN    = GEN_NEWER,
  parameter logic [15:0] DEV_ID = 16'h0000,
  parameter logic [7:0]  REV_ID = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic [CFG_AW-1:0]      off_i,
  input  logic [7:0]             data_i,
  output logic [CFG_BYTES*8-1:0] bytes_o
);

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam logic [7:0] RST_VAL = reset_byte(GEN, i, DEV_ID, REV_ID);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (commit_i && (off_i == CFG_AW'(i))) begin
        q <= data_i;
      end
    end
    assign bytes_o[i*8 +: 8] = q;
  end

endmodule

// File: rtl/bcfg_rd_port.sv
module bcfg_rd_port
  import bcfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_i,
  input  logic [FUNC_W-1:0]      func_i,
  input  logic [CFG_AW-1:0]      off_i,
  input  logic [CFG_BYTES*8-1:0] bytes_i,
  output logic                   rsp_valid_o,
  output logic [7:0]             rsp_data_o
);

  logic [7:0] sel;

  always_comb begin
    sel = bytes_i[{off_i, 3'b000} +: 8];
    if (func_i != '0) sel = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= 8'h00;
    end else begin
      rsp_valid_o <= rd_i;
      if (rd_i) rsp_data_o <= sel;
    end
  end

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bcfg_pkg::*;
#(
  parameter bcfg_gen_e   GEN    = GEN_NEWER,
  parameter logic [15:0] DEV_ID = 16'h1A2B,
  parameter logic [7:0]  REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [2:0]        req_func,
  input  logic [7:0]        req_off,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              cache_en,
  output logic [55:0]       attr_ctl,
  output logic [7:0]        smram_ctl
);

  logic                   commit;
  logic [7:0]             commit_data;
  logic [CFG_BYTES*8-1:0] cfg_bytes;

  assign req_ready = 1'b1;

  bcfg_wr_filter #(.GEN(GEN)) u_filter (
    .wr_i     (req_valid && req_we),
    .func_i   (req_func),
    .off_i    (req_off),
    .wdata_i  (req_wdata),
    .commit_o (commit),
    .data_o   (commit_data)
  );

  bcfg_store #(.GEN(GEN), .DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .off_i    (req_off),
    .data_i   (commit_data),
    .bytes_o  (cfg_bytes)
  );

  bcfg_rd_port u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_i        (req_valid && !req_we),
    .func_i      (req_func),
    .off_i       (req_off),
    .bytes_i     (cfg_bytes),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_rdata)
  );

  for (genvar k = 0; k < ATTR_N; k++) begin : g_attr
    assign attr_ctl[k*8 +: 8] = cfg_bytes[(OFF_ATTR0 + k)*8 +: 8];
  end

  assign smram_ctl = cfg_bytes[OFF_SMRAM*8 +: 8];
  assign cache_en  = cfg_bytes[OFF_CACHE*8];

endmodule

// File: rtl/bridge_cfg_regs_chk.sv
module bridge_cfg_regs_chk
  import bcfg_pkg::*;
#(
  parameter bcfg_gen_e GEN = GEN_NEWER
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic [2:0]  req_func,
  input logic [7:0]  req_off,
  input logic [7:0]  req_wdata,
  input logic        rsp_valid,
  input logic [7:0]  rsp_rdata,
  input logic        cache_en,
  input logic [55:0] attr_ctl,
  input logic [7:0]  smram_ctl
);

  localparam logic [7:0] HI_CMD_ALLOWED = (GEN == GEN_OLDER) ? 8'h01 : 8'h00;

  logic rd0, wr0;
  assign rd0 = req_valid && !req_we && (req_func == 3'd0);
  assign wr0 = req_valid && req_we && (req_func == 3'd0);

  AST_FUNC_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_func != 3'd0) |=> (rsp_valid && rsp_rdata == 8'hFF)); // R1

  AST_FUNC_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_func != 3'd0) |=>
      ($stable(smram_ctl) && $stable(attr_ctl) && $stable(cache_en))); // R1

  AST_VENDOR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && req_off == 8'h00) |=> (rsp_rdata == 8'h86)); // R2

  AST_CMD_BIT2_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && req_off == 8'h04) |=> rsp_rdata[2]); // R3

  AST_CMD_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && req_off == 8'h05) |=> ((rsp_rdata & ~HI_CMD_ALLOWED) == 8'h00)); // R4

  AST_STS_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && req_off == 8'h06) |=> (rsp_rdata == 8'h00)); // R5

  AST_CACHE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && req_off == 8'h52) |=> (cache_en == $past(req_wdata[0]))); // R9

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid); // R10

  AST_SMRAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && req_off == 8'h72) |=> (smram_ctl == $past(req_wdata))); // R11

endmodule

bind bridge_cfg_regs bridge_cfg_regs_chk #(.GEN(GEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_func  (req_func),
  .req_off   (req_off),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .cache_en  (cache_en),
  .attr_ctl  (attr_ctl),
  .smram_ctl (smram_ctl)
);

// File: tb/test_bridge_cfg_regs.sv
module test_bridge_cfg_regs;

  localparam int NG = 4;
  localparam logic [15:0] T_DEV = 16'hBEEF;
  localparam logic [7:0]  T_REV = 8'h05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid = 1'b0;
  logic       req_we = 1'b0;
  logic [2:0] req_func = 3'd0;
  logic [7:0] req_off = 8'h00;
  logic [7:0] req_wdata = 8'h00;

  logic        req_ready [NG];
  logic        rsp_valid [NG];
  logic [7:0]  rsp_rdata [NG];
  logic        cache_en  [NG];
  logic [55:0] attr_ctl  [NG];
  logic [7:0]  smram_ctl [NG];

  for (genvar g = 0; g < NG; g++) begin : g_dut
    bridge_cfg_regs #(.GEN(bcfg_pkg::bcfg_gen_e'(g)), .DEV_ID(T_DEV), .REV_ID(T_REV)) i_bridge_cfg_regs (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready[g]),
      .req_we(req_we), .req_func(req_func), .req_off(req_off), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid[g]), .rsp_rdata(rsp_rdata[g]), .cache_en(cache_en[g]),
      .attr_ctl(attr_ctl[g]), .smram_ctl(smram_ctl[g])
    );
  end

  int vectors = 0;
  int errors = 0;
  int model [NG][256];
  bit exp_rv;
  int exp_rd [NG];
  string cur_req = "R7";

  function automatic int model_default(int g, int off);
    if (off == 0) return 'h86;
    if (off == 1) return 'h80;
    if (off == 2) return int'(T_DEV[7:0]);
    if (off == 3) return int'(T_DEV[15:8]);
    if (off == 4 || off == 'h0B) return 6;
    if (off == 7) return 2;
    if (off == 8) return int'(T_REV);
    if (off >= 'h60 && off <= 'h64) return 2;
    if (off == 'h57) return (g == 0) ? 'h31 : 'h01;
    if (off == 'h72) return (g == 0) ? 0 : 2;
    return 0;
  endfunction

  function automatic int model_store(int g, int off, int v, int old);
    if (off < 4 || (off >= 8 && off <= 12) || off == 14 || (off >= 16 && off <= 'h4E)) return old;
    case (off)
      4: begin
        if (g == 0) return (v & 'h42) | 4;
        if (g == 2) return (v & 'h06) | 4;
        return (v & 'h02) | 4;
      end
      5: return (g == 0) ? (v & 1) : 0;
      6: return 0;
      7: begin
        if (g == 3) return (v & 'h80) | 2;
        return (g == 2) ? 'h22 : 'h02;
      end
      default: return v;
    endcase
  endfunction

  function automatic string tag_of(int off);
    if (off < 4 || (off >= 8 && off <= 12) || off == 14 || (off >= 16 && off <= 'h4E)) return "R2";
    if (off == 4) return "R3";
    if (off == 5) return "R4";
    if (off == 6) return "R5";
    if (off == 7) return "R6";
    if (off == 'h52) return "R9";
    if ((off >= 'h59 && off <= 'h5F) || off == 'h72) return "R11";
    return "R12";
  endfunction

  task automatic check(string req, string what, int g, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s gen%0d %s: actual %02h expected %02h", req, g, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int g = 0; g < NG; g++) begin
      logic [55:0] ea;
      for (int k = 0; k < 7; k++) ea[k*8 +: 8] = 8'(model[g]['h59 + k]);
      check("R10", "req_ready", g, int'(req_ready[g]), 1);
      check(exp_rv ? cur_req : "R10", "rsp_valid", g, int'(rsp_valid[g]), int'(exp_rv));
      if (exp_rv) check(cur_req, "rsp_rdata", g, int'(rsp_rdata[g]), exp_rd[g]);
      check("R9", "cache_en", g, int'(cache_en[g]), model[g]['h52] & 1);
      vectors++;
      if (attr_ctl[g] !== ea) begin
        errors++;
        $display("FAIL R11 gen%0d attr_ctl: actual %014h expected %014h", g, attr_ctl[g], ea);
      end
      check("R11", "smram_ctl", g, int'(smram_ctl[g]), model[g]['h72]);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic access(bit v, bit we, int func, int off, int data);
    req_valid = v; req_we = we; req_func = 3'(func); req_off = 8'(off); req_wdata = 8'(data);
    @(posedge clk);
    exp_rv = v && !we;
    for (int g = 0; g < NG; g++) begin
      if (v && !we) exp_rd[g] = (func != 0) ? 'hFF : model[g][off];
      if (v && we && func == 0) model[g][off] = model_store(g, off, data, model[g][off]);
    end
    @(negedge clk);
    compare_all();
    req_valid = 1'b0;
  endtask

  task automatic read_all(bit rst_phase);
    for (int o = 0; o < 256; o++) begin
      if (rst_phase) cur_req = (o == 'h57 || o == 'h72) ? "R8" : "R7";
      else cur_req = tag_of(o);
      access(1, 0, 0, o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++)
      for (int o = 0; o < 256; o++) model[g][o] = model_default(g, o);
    exp_rv = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R7";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);

    // R7 / R8: reset contents
    read_all(1);

    // R2..R6, R9, R11, R12: all ones, all zeros, mixed patterns
    for (int o = 0; o < 256; o++) begin cur_req = tag_of(o); access(1, 1, 0, o, 'hFF); end
    read_all(0);
    for (int o = 0; o < 256; o++) begin cur_req = tag_of(o); access(1, 1, 0, o, 'h00); end
    read_all(0);
    for (int o = 0; o < 256; o++) begin cur_req = tag_of(o); access(1, 1, 0, o, (o ^ 'hA5) & 'hFF); end
    read_all(0);
    for (int o = 0; o < 256; o++) begin cur_req = tag_of(o); access(1, 1, 0, o, (o * 7 + 'h3C) & 'hFF); end
    read_all(0);

    // R1: nonzero functions must neither write nor read stored data
    cur_req = "R1";
    for (int f = 1; f < 8; f++) begin
      access(1, 1, f, 'h72, 'h5A ^ f);
      access(1, 1, f, 'h52, f);
      access(1, 1, f, 'h5C, 'hC3);
      access(1, 1, f, 'h04, 'hFF);
      access(1, 0, f, 'h00, 0);
      access(1, 0, f, 'h72, 0);
    end
    cur_req = "R1";
    access(1, 0, 0, 'h72, 0);
    access(1, 0, 0, 'h04, 0);

    // R10: writes with valid low are inert; back-to-back write/read; idle gaps
    cur_req = "R10";
    access(0, 1, 0, 'h72, 'hE7);
    access(0, 1, 0, 'h52, 'h01);
    access(0, 0, 0, 'h72, 0);
    access(1, 0, 0, 'h72, 0);
    access(1, 1, 0, 'h90, 'h3E);
    access(1, 0, 0, 'h90, 0);
    access(1, 1, 0, 'h90, 'hC1);
    access(1, 0, 0, 'h90, 0);
    access(0, 0, 0, 0, 0);

    // R9 / R11: toggle exported bytes and watch outputs
    cur_req = "R9";
    access(1, 1, 0, 'h52, 'h01);
    access(1, 1, 0, 'h52, 'hFE);
    access(1, 1, 0, 'h52, 'h03);
    cur_req = "R11";
    for (int k = 0; k < 7; k++) access(1, 1, 0, 'h59 + k, 'h11 * (k + 1));
    access(1, 1, 0, 'h72, 'h48);
    access(0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule